// File: doc/BRIEF.md
# Load-Store Byte Lane Alignment Unit

This unit sits between the memory stage of a 32-bit integer pipeline and a word-wide, byte-addressable, little-endian data memory. Each cycle the pipeline may present one access: a load or a store of a byte, a halfword or a word, together with the effective byte address, the store data and a flag that selects zero extension for loads. The unit turns that into a word-addressed memory request, with per-lane write enables and lane-replicated write data for stores.

Load data comes back from the memory one cycle after the request. The unit keeps the byte offset, the size and the extension mode of the load in registers. When the read word returns, it selects the addressed lanes, shifts them down to bit 0 and extends them to 32 bits. An access whose address is not a multiple of its size raises an error flag in the same cycle. Such an access reaches neither the memory nor the register file. Address generation and the handling of the error belong to other blocks.

Top module: `lsu_lane_align`

## Requirements
- R1: For a valid, aligned access, `mem_req` is 1 and `mem_word_addr` equals bits 31:2 of `req_addr`, so a byte address that is 4 higher selects the next word.
- R2: `misalign` is 1 when a valid request has size code 1 (halfword) with address bit 0 set, size code 2 (word) with address bits 1:0 non-zero, or the reserved size code 3 at any address. It is 0 for size code 0 (byte) and whenever `req_valid` is 0.
- R3: A misaligned request drives `mem_req` 0, `mem_we` 0 and `mem_be` 4'b0000, and it produces no `ld_valid` in the next cycle.
- R4: For an aligned store, `mem_be` is 4'b0001 shifted left by address bits 1:0 for a byte, 4'b0011 for a halfword at offset 0 or 4'b1100 at offset 2, and 4'b1111 for a word. `mem_we` is 1.
- R5: Store data is placed on every lane the access could use. A byte store drives bits 7:0 of `req_wdata` onto all four lanes. A halfword store drives bits 15:0 onto both halves. A word store passes the data through unchanged. The upper source bits of a narrow store never reach memory.
- R6: Little-endian lane selection for loads. The byte at offset k is `mem_rdata[8k+7:8k]`. A halfword at offset 0 is bits 15:0, and one at offset 2 is bits 31:16.
- R7: A load with `req_unsigned` = 0 fills bits 31:8 (byte) or 31:16 (halfword) of `ld_data` with the top bit of the loaded item.
- R8: A load with `req_unsigned` = 1 fills those upper bits with zeros. A word load returns the memory word unchanged.
- R9: `ld_valid` is 1 in exactly the cycle after an aligned load request, and `ld_data` is valid in that cycle. A load drives `mem_we` 0 and `mem_be` 4'b0000.
- R10: While `rst_n` is 0, and in the first cycle after it, `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned | input | 1 | Zero-extend a narrow load |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store source register value |
| misalign | output | 1 | Access not aligned to its size |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_word_addr | output | 30 | Word address to memory |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, one cycle after `mem_req` |
| ld_valid | output | 1 | Load result is valid |
| ld_data | output | 32 | Extended load result |

## Verification
Some properties are checked by assertions on every cycle. A misaligned access stays off the memory. Write-enable patterns have legal lane counts. A load strobes no lanes. `ld_valid` follows an aligned load exactly one cycle later. The upper bits of every narrow load result equal either the sign bit or zero, as the request's mode demands.

Other properties can only be shown by the bench's scenarios, which keep a byte-wide shadow of memory. These are:
- which lanes a store actually writes;
- that the upper source bits never land in memory;
- that the returned bytes come from the right little-endian position;
- that the word address steps by one per 4 bytes.

// File: rtl/lsu_lane_pkg.sv
// Shared types for the load-store lane alignment unit.
// Assumes a 4-byte word; the size code selects 1, 2 or 4 bytes.
package lsu_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

endpackage

// File: rtl/lsu_align_check.sv
// Alignment checker: flags an access whose byte offset is not a multiple
// of its size, and treats the reserved size code as always misaligned.
// Assumes OFF_W >= 2 (at least a 4-byte word).
module lsu_align_check
    import lsu_lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             valid,
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misalign
);

    logic bad;

    // Decide whether the offset suits the access size.
    always_comb begin
        case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = |off;
            default: bad = 1'b1;
        endcase
    end

    assign misalign = valid & bad;

endmodule

// File: rtl/lsu_store_lane.sv
// Store lane steering: computes per-lane write enables from size and offset
// and replicates the low byte or halfword of the source onto every lane.
// Assumes the caller gates `en` with alignment; OFF_W >= 2.
module lsu_store_lane
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / BYTE_W,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              en,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
        logic              hit;
        logic [BYTE_W-1:0] lane;

        // Decide whether this lane belongs to the access.
        always_comb begin
            case (size)
                SZ_BYTE: hit = (off == IDX);
                SZ_HALF: hit = (off[OFF_W-1:1] == IDX[OFF_W-1:1]);
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end

        // Pick which source byte this lane carries.
        always_comb begin
            case (size)
                SZ_BYTE: lane = src[BYTE_W-1:0];
                SZ_HALF: lane = src[BYTE_W*(i%2) +: BYTE_W];
                default: lane = src[BYTE_W*i +: BYTE_W];
            endcase
        end

        assign be[i]                    = en & hit;
        assign wdata[BYTE_W*i +: BYTE_W] = lane;
    end

endmodule

// File: rtl/lsu_load_extract.sv
// Load extraction: shifts the addressed lanes of the read word down to
// bit 0 and sign- or zero-extends a byte or halfword to the full width.
// Assumes the offset is already known to be aligned.
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / BYTE_W,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              zext,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);

    logic [DATA_W-1:0] shifted;
    logic              fill_b;
    logic              fill_h;

    assign shifted = rdata >> {off, 3'b000};
    assign fill_b  = ~zext & shifted[BYTE_W-1];
    assign fill_h  = ~zext & shifted[HALF_W-1];

    // Extend the selected item to the register width.
    always_comb begin
        case (size)
            SZ_BYTE: data = {{(DATA_W-BYTE_W){fill_b}}, shifted[BYTE_W-1:0]};
            SZ_HALF: data = {{(DATA_W-HALF_W){fill_h}}, shifted[HALF_W-1:0]};
            default: data = shifted;
        endcase
    end

endmodule

// File: rtl/lsu_lane_align.sv
// Top of the load-store lane alignment unit. Requests are steered to the
// word-wide memory in the same cycle; the load context is registered so that
// the word returned one cycle later can be extracted and extended.
// Assumes a memory with exactly one cycle of read latency.
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic                               req_store,
    input  logic [1:0]                         req_size,
    input  logic                               req_unsigned,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [DATA_W-1:0]                  req_wdata,
    output logic                               misalign,
    output logic                               mem_req,
    output logic                               mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_word_addr,
    output logic [DATA_W/8-1:0]                mem_be,
    output logic [DATA_W-1:0]                  mem_wdata,
    input  logic [DATA_W-1:0]                  mem_rdata,
    output logic                               ld_valid,
    output logic [DATA_W-1:0]                  ld_data
);

    localparam int LANES = DATA_W / BYTE_W;
    localparam int OFF_W = $clog2(LANES);

    acc_size_e        size_in;
    logic [OFF_W-1:0] off_in;
    logic             load_go;

    acc_size_e        ctx_size;
    logic [OFF_W-1:0] ctx_off;
    logic             ctx_zext;

    assign size_in = acc_size_e'(req_size);
    assign off_in  = req_addr[OFF_W-1:0];

    lsu_align_check #(.OFF_W(OFF_W)) u_align (
        .valid    (req_valid),
        .size     (size_in),
        .off      (off_in),
        .misalign (misalign)
    );

    assign mem_req       = req_valid & ~misalign;
    assign mem_we        = mem_req & req_store;
    assign mem_word_addr = req_addr[ADDR_W-1:OFF_W];
    assign load_go       = mem_req & ~req_store;

    lsu_store_lane #(.DATA_W(DATA_W)) u_store (
        .en    (mem_we),
        .size  (size_in),
        .off   (off_in),
        .src   (req_wdata),
        .be    (mem_be),
        .wdata (mem_wdata)
    );

    // Hold the load context until the read word returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ctx_size <= SZ_WORD;
            ctx_off  <= '0;
            ctx_zext <= 1'b0;
        end else begin
            ld_valid <= load_go;
            if (load_go) begin
                ctx_size <= size_in;
                ctx_off  <= off_in;
                ctx_zext <= req_unsigned;
            end
        end
    end

    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .size  (ctx_size),
        .off   (ctx_off),
        .zext  (ctx_zext),
        .rdata (mem_rdata),
        .data  (ld_data)
    );

endmodule

// File: rtl/lsu_lane_align_chk.sv
// Property checker for lsu_lane_align, attached to every instance by bind.
// Assumes the default 32-bit data width.
module lsu_lane_align_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_store,
    input logic [1:0]  req_size,
    input logic        req_unsigned,
    input logic [31:0] req_addr,
    input logic        misalign,
    input logic        mem_req,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic        ld_valid,
    input logic [31:0] ld_data
);

    logic ld_go;
    assign ld_go = req_valid && !req_store && !misalign;

    p_err_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> req_valid);

    p_byte_never_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |-> !misalign);

    p_misalign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_req && !mem_we && mem_be == 4'b0000));

    p_misalign_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !ld_valid);

    p_be_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                    $countones(mem_be) == 4));

    p_sext_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && req_size == 2'd0 && !req_unsigned)
            |=> (ld_data[31:8] == {24{ld_data[7]}}));

    p_sext_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && req_size == 2'd1 && !req_unsigned)
            |=> (ld_data[31:16] == {16{ld_data[15]}}));

    p_zext_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && req_size == 2'd0 && req_unsigned) |=> (ld_data[31:8] == 24'd0));

    p_zext_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && req_size == 2'd1 && req_unsigned) |=> (ld_data[31:16] == 16'd0));

    p_load_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> ld_valid);

    p_load_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(ld_go));

    p_load_no_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !req_store) |-> (!mem_we && mem_be == 4'b0000));

    p_addr_unused_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd2 && req_addr[1:0] == 2'b00) |-> mem_req);

endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (.*);

// File: tb/sim_lsu_lane_align.sv
// Bench: byte-wide shadow memory as reference, word array as the memory
// model, every cycle's outputs compared against behaviourally computed values.
module sim_lsu_lane_align;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        misalign;
    logic        mem_req;
    logic        mem_we;
    logic [29:0] mem_word_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] mem_arr [MEM_WORDS];
    logic [7:0]  shadow  [MEM_WORDS*4];

    logic        pend_v = 1'b0;
    logic [31:0] pend_d = '0;
    string       pend_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_lane_align u0 (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_store (req_store),
        .req_size (req_size), .req_unsigned (req_unsigned), .req_addr (req_addr),
        .req_wdata (req_wdata), .misalign (misalign), .mem_req (mem_req),
        .mem_we (mem_we), .mem_word_addr (mem_word_addr), .mem_be (mem_be),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .ld_valid (ld_valid),
        .ld_data (ld_data)
    );

    // Word memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int i = 0; i < 4; i++)
                    if (mem_be[i]) mem_arr[mem_word_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
            end else begin
                mem_rdata <= mem_arr[mem_word_addr[3:0]];
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: check last cycle's load result, then drive and check a new request.
    task automatic step(logic v, logic st, logic [1:0] sz, logic uns,
                        logic [31:0] a, logic [31:0] d);
        logic        e_mis;
        logic [3:0]  e_be;
        logic [31:0] e_wd;
        logic [5:0]  b;
        logic [31:0] raw;
        @(negedge clk);
        check("R9 ld_valid", {31'd0, ld_valid}, {31'd0, pend_v});
        if (pend_v) check(pend_tag, ld_data, pend_d);
        req_valid = v; req_store = st; req_size = sz; req_unsigned = uns;
        req_addr = a; req_wdata = d;
        #1;
        case (sz)
            2'd0: e_mis = 1'b0;
            2'd1: e_mis = a[0];
            2'd2: e_mis = (a[1:0] != 2'b00);
            default: e_mis = 1'b1;
        endcase
        e_mis = e_mis & v;
        check("R2 misalign", {31'd0, misalign}, {31'd0, e_mis});
        if (!v || e_mis) begin
            check("R3 quiet", {26'd0, mem_req, mem_we, mem_be}, 32'd0);
        end else begin
            check("R1 mem_req", {31'd0, mem_req}, 32'd1);
            check("R1 word addr", {2'b00, mem_word_addr}, {2'b00, a[31:2]});
        end
        pend_v = 1'b0;
        if (v && !e_mis && st) begin
            case (sz)
                2'd0: begin e_be = 4'b0001 << a[1:0]; e_wd = {4{d[7:0]}}; end
                2'd1: begin e_be = 4'b0011 << a[1:0]; e_wd = {2{d[15:0]}}; end
                default: begin e_be = 4'hF; e_wd = d; end
            endcase
            check("R4 mem_be", {27'd0, mem_we, mem_be}, {27'd0, 1'b1, e_be});
            check("R5 mem_wdata", mem_wdata, e_wd);
            b = {a[5:2], 2'b00};
            for (int i = 0; i < 4; i++)
                if (e_be[i]) shadow[b + 6'(i)] = e_wd[8*i +: 8];
        end else if (v && !e_mis) begin
            check("R9 load no be", {27'd0, mem_we, mem_be}, 32'd0);
            b = a[5:0];
            raw = {shadow[b | 6'd3], shadow[b | 6'd2], shadow[b | 6'd1], shadow[b]};
            case (sz)
                2'd0: pend_d = uns ? {24'd0, raw[7:0]} : {{24{raw[7]}}, raw[7:0]};
                2'd1: pend_d = uns ? {16'd0, raw[15:0]} : {{16{raw[15]}}, raw[15:0]};
                default: pend_d = raw;
            endcase
            pend_tag = (sz == 2'd2) ? "R6 R8 word load" :
                       (uns ? "R6 R8 unsigned load" : "R6 R7 signed load");
            pend_v = 1'b1;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS*4; i++) shadow[i] = 8'(i * 37 + 11);
        for (int w = 0; w < MEM_WORDS; w++)
            mem_arr[w] = {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]};
        // R10: reset state
        repeat (3) begin
            @(negedge clk);
            check("R10 reset ld_valid", {31'd0, ld_valid}, 32'd0);
        end
        rst_n = 1'b1;
        step(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0);
        // R6 R7 R8: loads of every size and offset, both modes, from initial contents
        for (int off = 0; off < 4; off++) begin
            step(1'b1, 1'b0, 2'd0, 1'b0, 32'h0000_0010 + 32'(off), 32'h0);
            step(1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_0014 + 32'(off), 32'h0);
        end
        step(1'b1, 1'b0, 2'd1, 1'b0, 32'h0000_0020, 32'h0);
        step(1'b1, 1'b0, 2'd1, 1'b1, 32'h0000_0022, 32'h0);
        step(1'b1, 1'b0, 2'd2, 1'b0, 32'h0000_0024, 32'h0);
        // R4 R5: narrow stores keep only their low bits, then read back
        step(1'b1, 1'b1, 2'd0, 1'b0, 32'h0000_0031, 32'hDEAD_BE85);
        step(1'b1, 1'b1, 2'd1, 1'b0, 32'h0000_0036, 32'h1234_F00D);
        step(1'b1, 1'b1, 2'd2, 1'b0, 32'h0000_0038, 32'h8081_7F80);
        step(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0);
        step(1'b1, 1'b0, 2'd2, 1'b0, 32'h0000_0030, 32'h0);
        step(1'b1, 1'b0, 2'd2, 1'b0, 32'h0000_0034, 32'h0);
        step(1'b1, 1'b0, 2'd0, 1'b0, 32'h0000_0031, 32'h0);
        step(1'b1, 1'b0, 2'd1, 1'b0, 32'h0000_0036, 32'h0);
        step(1'b1, 1'b0, 2'd1, 1'b1, 32'h0000_0036, 32'h0);
        step(1'b1, 1'b0, 2'd0, 1'b0, 32'h0000_0038, 32'h0);
        step(1'b1, 1'b0, 2'd0, 1'b0, 32'h0000_003B, 32'h0);
        // R1: next word at address + 4, high address bits carried
        step(1'b1, 1'b0, 2'd2, 1'b0, 32'hA5A5_0FF0, 32'h0);
        step(1'b1, 1'b0, 2'd2, 1'b0, 32'hA5A5_0FF4, 32'h0);
        // R2 R3: misaligned halfword, word, reserved size; load and store
        step(1'b1, 1'b0, 2'd1, 1'b0, 32'h0000_0011, 32'h0);
        step(1'b1, 1'b1, 2'd1, 1'b0, 32'h0000_0013, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, 2'd2, 1'b0, 32'h0000_0012, 32'h0);
        step(1'b1, 1'b1, 2'd2, 1'b0, 32'h0000_0011, 32'hFFFF_FFFF);
        step(1'b1, 1'b1, 2'd3, 1'b0, 32'h0000_0010, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, 2'd3, 1'b0, 32'h0000_0010, 32'h0);
        // R3: rejected stores above must have left memory untouched
        step(1'b1, 1'b0, 2'd2, 1'b0, 32'h0000_0010, 32'h0);
        // Mixed random traffic over the modelled window
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[2], r[4:3], r[5],
                 {r[31:24], 18'd0, r[11:6]}, $urandom);
        end
        step(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0);
        step(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule